// File: doc/BRIEF.md
# Inter-CPU Doorbell Unit

The doorbell unit lets any agent ring one numbered doorbell in a chosen group of CPUs with a single write. Each CPU owns a 32-bit pending word and a 32-bit enable word. A trigger write carries two things: a doorbell number and a map of target CPUs. Every targeted CPU gets that one pending bit set. Software running on a CPU finds out which doorbells rang by reading its own pending word. It acknowledges them by writing the word back with zeros in the positions it has handled.

The 32 pending bits form two groups, each with its own interrupt line per CPU. Bits 0 to 7 carry processor-to-processor messages. Bits 16 to 31 are targets for message-signalled interrupts from devices. Such a device writes 0xF00 | (16 + n) to the trigger address, which rings bit 16 + n in all four CPUs. Bits 8 to 15 can be set and read but drive neither line.

The CPU-side register bus presents a CPU index with every access, and that index picks whose pending or enable word is touched. A second, write-only trigger port takes device writes, so a device can ring a doorbell in the same cycle that a CPU clears its pending word.

Top module: `dbell_hub`

## Requirements
- R1: After a synchronous reset, every pending word and every enable word reads 0, and all interrupt outputs are low.
- R2: A bus write to offset 0x4 (trigger) with doorbell number data[4:0] sets that bit in the pending word of each CPU k for which data[8+k] is 1. Other bits and other CPUs are left unchanged.
- R3: A trigger with an all-zero CPU map changes no pending word. Cycles with no write leave every pending word unchanged.
- R4: A bus write to offset 0x8 (pending) for the indexed CPU clears each bit written as 0 and keeps each bit written as 1. It never sets a bit.
- R5: Writing 0 to a CPU's pending word clears all of its pending doorbells.
- R6: A bus write to offset 0xC (enable) replaces the indexed CPU's enable word. Offsets 0x8 and 0xC read back the indexed CPU's pending and enable words.
- R7: ipi_irq[k] is high exactly when some bit among pending[7:0] & enable[7:0] of CPU k is 1.
- R8: msg_irq[k] is high exactly when some bit among pending[31:16] & enable[31:16] of CPU k is 1. Bits 8 to 15 affect neither output.
- R9: If a set from any trigger and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: A trigger-port write of 0xF00 | (16 + n), for n in 0 to 15, sets bit 16 + n in all four CPUs.
- R11: Bus writes to any offset other than 0x4, 0x8 and 0xC change nothing, and reads from such offsets return 0.
- R12: Pending and enable writes affect only the CPU selected by the bus CPU index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_cpu | input | 2 | CPU index of the access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr and bus_cpu (combinational) |
| trig_wr | input | 1 | Device trigger write strobe |
| trig_data | input | 32 | Device trigger word (number in [4:0], CPU map in [11:8]) |
| ipi_irq | output | 4 | Per-CPU processor-message interrupt |
| msg_irq | output | 4 | Per-CPU message-signalled interrupt |

## Verification
The trigger is swept over every doorbell number and every one of the 16 CPU maps. Reading all four pending words after each trigger separates a wrong bit position from a wrong or missing target, and the empty map shows whether a stray set occurs. Partial-clear patterns are applied to a full pending word to tell clear-on-zero apart from clear-on-one and from a plain overwrite. Single pending bits are swept against the enable patterns 0xFF, 0xFFFF0000, all-ones and zero, which catches a line that is driven by the wrong group or by the gap bits 8 to 15. A same-cycle clear and device trigger, plus writes to every unused offset, cover set priority and address decode.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int NUM_W   = 5;
    localparam int MAP_LSB = 8;

    localparam logic [ADDR_W-1:0] OFF_TRIG  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 4'hC;

    localparam int IPI_LO = 0;
    localparam int IPI_HI = 7;
    localparam int MSG_LO = 16;
    localparam int MSG_HI = 31;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_TRIG,
        RSEL_CAUSE,
        RSEL_MASK
    } rsel_e;

    typedef struct packed {
        logic             valid;
        logic [NUM_W-1:0] num;
    } ring_t;

    function automatic rsel_e decode_off(logic [ADDR_W-1:0] a);
        case (a)
            OFF_TRIG:  return RSEL_TRIG;
            OFF_CAUSE: return RSEL_CAUSE;
            OFF_MASK:  return RSEL_MASK;
            default:   return RSEL_NONE;
        endcase
    endfunction

    function automatic word_t bit_of(logic [NUM_W-1:0] n);
        return word_t'(1) << n;
    endfunction

    function automatic word_t span(int lo, int hi);
        word_t s;
        s = '0;
        for (int i = lo; i <= hi; i++) s[i] = 1'b1;
        return s;
    endfunction

    function automatic logic group_any(word_t pend, word_t en, int lo, int hi);
        return |(pend & en & span(lo, hi));
    endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int CIDX_W = 2
) (
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [CIDX_W-1:0]            bus_cpu,
    input  word_t                        bus_wdata,
    input  logic                         trig_wr,
    input  word_t                        trig_data,
    output rsel_e                        rsel,
    output logic [N_CPU-1:0][DATA_W-1:0] set_vec,
    output logic [N_CPU-1:0]             cause_we,
    output logic [N_CPU-1:0]             mask_we
);

    ring_t ring_bus;
    ring_t ring_dev;

    always_comb begin
        rsel           = decode_off(bus_addr);
        ring_bus.valid = bus_wr && (rsel == RSEL_TRIG);
        ring_bus.num   = bus_wdata[NUM_W-1:0];
        ring_dev.valid = trig_wr;
        ring_dev.num   = trig_data[NUM_W-1:0];
    end

    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        logic hit_bus;
        logic hit_dev;
        logic sel_me;
        always_comb begin
            hit_bus     = ring_bus.valid && bus_wdata[MAP_LSB+g];
            hit_dev     = ring_dev.valid && trig_data[MAP_LSB+g];
            set_vec[g]  = (hit_bus ? bit_of(ring_bus.num) : '0)
                        | (hit_dev ? bit_of(ring_dev.num) : '0);
            sel_me      = bus_wr && (bus_cpu == CIDX_W'(g));
            cause_we[g] = sel_me && (rsel == RSEL_CAUSE);
            mask_we[g]  = sel_me && (rsel == RSEL_MASK);
        end
    end

endmodule

// File: rtl/dbell_bank.sv
module dbell_bank
    import dbell_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t set_vec,
    input  logic  cause_we,
    input  logic  mask_we,
    input  word_t wdata,
    output word_t cause_q,
    output word_t mask_q,
    output logic  ipi_irq,
    output logic  msg_irq
);

    word_t keep;
    word_t cause_d;

    always_comb begin
        keep    = cause_we ? wdata : '1;
        cause_d = (cause_q & keep) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= cause_d;
            if (mask_we) mask_q <= wdata;
        end
    end

    always_comb begin
        ipi_irq = group_any(cause_q, mask_q, IPI_LO, IPI_HI);
        msg_irq = group_any(cause_q, mask_q, MSG_LO, MSG_HI);
    end

    // R9: a requested set is present the cycle after, whatever the clear did
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

    // R4: a pending bit only rises when a set asked for it
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0));

    // R5: writing zero with no concurrent set empties the word
    a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
        (cause_we && (wdata == '0) && (set_vec == '0)) |=> (cause_q == '0));

    // R6: enable word only moves on its own write
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));

endmodule

// File: rtl/dbell_rdmux.sv
module dbell_rdmux
    import dbell_pkg::*;
#(
    parameter int N_CPU  = 4,
    parameter int CIDX_W = 2
) (
    input  rsel_e                        rsel,
    input  logic [CIDX_W-1:0]            cpu,
    input  logic [N_CPU-1:0][DATA_W-1:0] cause_all,
    input  logic [N_CPU-1:0][DATA_W-1:0] mask_all,
    output word_t                        rdata
);

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_CPU; k++) begin
            if (cpu == CIDX_W'(k)) begin
                case (rsel)
                    RSEL_CAUSE: rdata = cause_all[k];
                    RSEL_MASK:  rdata = mask_all[k];
                    default:    rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dbell_hub.sv
module dbell_hub
    import dbell_pkg::*;
#(
    parameter  int N_CPU  = 4,
    localparam int CIDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CIDX_W-1:0] bus_cpu,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_wr,
    input  logic [DATA_W-1:0] trig_data,
    output logic [N_CPU-1:0]  ipi_irq,
    output logic [N_CPU-1:0]  msg_irq
);

    rsel_e                        rsel;
    logic [N_CPU-1:0][DATA_W-1:0] set_vec;
    logic [N_CPU-1:0]             cause_we;
    logic [N_CPU-1:0]             mask_we;
    logic [N_CPU-1:0][DATA_W-1:0] cause_all;
    logic [N_CPU-1:0][DATA_W-1:0] mask_all;

    dbell_decode #(.N_CPU(N_CPU), .CIDX_W(CIDX_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_cpu   (bus_cpu),
        .bus_wdata (bus_wdata),
        .trig_wr   (trig_wr),
        .trig_data (trig_data),
        .rsel      (rsel),
        .set_vec   (set_vec),
        .cause_we  (cause_we),
        .mask_we   (mask_we)
    );

    for (genvar g = 0; g < N_CPU; g++) begin : g_bank
        dbell_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .set_vec  (set_vec[g]),
            .cause_we (cause_we[g]),
            .mask_we  (mask_we[g]),
            .wdata    (bus_wdata),
            .cause_q  (cause_all[g]),
            .mask_q   (mask_all[g]),
            .ipi_irq  (ipi_irq[g]),
            .msg_irq  (msg_irq[g])
        );
    end

    dbell_rdmux #(.N_CPU(N_CPU), .CIDX_W(CIDX_W)) u_rd (
        .rsel      (rsel),
        .cpu       (bus_cpu),
        .cause_all (cause_all),
        .mask_all  (mask_all),
        .rdata     (bus_rdata)
    );

    // R3: with no write of any kind, no pending word moves
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !trig_wr) |=> $stable(cause_all));

    // R12: a pending or enable write strobes at most one CPU
    a_r12_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause_we | mask_we));

endmodule

// File: tb/sim_dbell_hub.sv
module sim_dbell_hub;
    import dbell_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC         = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [1:0]  bus_cpu;
    word_t       bus_wdata;
    word_t       bus_rdata;
    logic        trig_wr;
    word_t       trig_data;
    logic [NC-1:0] ipi_irq;
    logic [NC-1:0] msg_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_hub #(.N_CPU(NC)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_cpu(bus_cpu), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_wr(trig_wr), .trig_data(trig_data),
        .ipi_irq(ipi_irq), .msg_irq(msg_irq)
    );

    int    checks = 0;
    int    errors = 0;
    word_t exp_cause [NC];
    word_t exp_mask  [NC];

    task automatic chk(input bit ok, input string req, input word_t act, input word_t exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [3:0] a, input int c, input word_t d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_cpu = 2'(c); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tw(input word_t d);
        @(negedge clk);
        trig_wr = 1'b1; trig_data = d;
        @(negedge clk);
        trig_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input int c, output word_t d);
        bus_addr = a; bus_cpu = 2'(c);
        #1 d = bus_rdata;
    endtask

    function automatic void model_ring(input word_t d);
        for (int c = 0; c < NC; c++)
            if (d[8+c]) exp_cause[c] |= word_t'(1) << d[4:0];
    endfunction

    task automatic check_all(input string req);
        word_t v;
        for (int c = 0; c < NC; c++) begin
            rd(OFF_CAUSE, c, v);
            chk(v == exp_cause[c], req, v, exp_cause[c]);
            rd(OFF_MASK, c, v);
            chk(v == exp_mask[c], req, v, exp_mask[c]);
        end
    endtask

    task automatic clear_all();
        for (int c = 0; c < NC; c++) begin
            bw(OFF_CAUSE, c, '0);
            exp_cause[c] = '0;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        word_t v;
        bus_wr = 0; bus_addr = 0; bus_cpu = 0; bus_wdata = 0;
        trig_wr = 0; trig_data = 0; rst = 1'b1;
        for (int c = 0; c < NC; c++) begin exp_cause[c] = '0; exp_mask[c] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1 reset");
        chk(ipi_irq == '0 && msg_irq == '0, "R1 irq", word_t'({msg_irq, ipi_irq}), '0);

        // R6 / R12: distinct enable words, each landing only on its CPU
        for (int c = 0; c < NC; c++) begin
            exp_mask[c] = 32'hA5A5_0000 ^ (32'h1111_1111 * (c + 1));
            bw(OFF_MASK, c, exp_mask[c]);
            check_all("R6 R12 mask write");
        end

        // R2 / R3 / R5: every map by every doorbell number
        for (int m = 0; m < 16; m++) begin
            for (int n = 0; n < 32; n++) begin
                word_t d;
                d = word_t'(n) | (word_t'(m) << 8);
                bw(OFF_TRIG, 0, d);
                model_ring(d);
                check_all(m == 0 ? "R3 empty map" : "R2 trigger sweep");
                clear_all();
            end
            check_all("R5 clear to zero");
        end

        // R4: partial clears on a full pending word
        begin
            word_t pats [4] = '{32'hFFFF_00FF, 32'h0000_0000, 32'h5A5A_C3C3, 32'h8000_0001};
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 32; n++) tw(word_t'(n) | 32'h0000_0200);
                for (int n = 0; n < 32; n++) model_ring(word_t'(n) | 32'h0000_0200);
                check_all("R4 fill");
                bw(OFF_CAUSE, 1, pats[p]);
                exp_cause[1] &= pats[p];
                check_all("R4 partial clear");
                clear_all();
            end
        end

        // R7 / R8: single pending bit against enable patterns
        begin
            word_t mk [4] = '{32'h0000_00FF, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_0000};
            for (int c = 0; c < NC; c++) begin
                for (int p = 0; p < 4; p++) begin
                    bw(OFF_MASK, c, mk[p]);
                    exp_mask[c] = mk[p];
                    for (int n = 0; n < 32; n++) begin
                        logic ei, em;
                        tw(word_t'(n) | (word_t'(1) << (8 + c)));
                        ei = (n <= 7) && mk[p][n];
                        em = (n >= 16) && mk[p][n];
                        #1;
                        chk(ipi_irq == (NC'(ei) << c), "R7 ipi line",
                            word_t'(ipi_irq), word_t'(NC'(ei) << c));
                        chk(msg_irq == (NC'(em) << c), "R8 msg line",
                            word_t'(msg_irq), word_t'(NC'(em) << c));
                        bw(OFF_CAUSE, c, '0);
                    end
                end
            end
            for (int c = 0; c < NC; c++) exp_cause[c] = '0;
            check_all("R7 R8 aftermath");
        end

        // R10: device message writes ring all four CPUs
        for (int n = 0; n < 16; n++) begin
            tw(32'h0000_0F00 | word_t'(16 + n));
            for (int c = 0; c < NC; c++) exp_cause[c] |= word_t'(1) << (16 + n);
            check_all("R10 message write");
        end
        clear_all();

        // R9: clear and device set on the same bit in the same cycle
        tw(32'h0000_0F14);
        model_ring(32'h0000_0F14);
        tw(32'h0000_0103);
        model_ring(32'h0000_0103);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = OFF_CAUSE; bus_cpu = 2'd0; bus_wdata = '0;
        trig_wr = 1'b1; trig_data = 32'h0000_0F14;
        @(negedge clk);
        bus_wr = 1'b0; trig_wr = 1'b0;
        exp_cause[0] = 32'h0010_0000;
        check_all("R9 set beats clear");

        // R11: unused offsets write nothing and read zero
        for (int a = 0; a < 16; a++) begin
            if (a == 4 || a == 8 || a == 12) continue;
            bw(4'(a), 1, '1);
            check_all("R11 unused offset write");
            rd(4'(a), 1, v);
            chk(v == '0, "R11 unused offset read", v, '0);
        end

        summary();
        $finish;
    end

endmodule